// File: doc/BRIEF.md
# Time-of-Day Counter with Schedule Pulses

This block keeps a 24-hour time of day as a binary minute and a binary hour. A slow system clock drives it. A wide prescaler counts clock cycles, and when it completes one minute's worth of cycles the minute advances. The minute carries into the hour, and the hour wraps after 23.

The counter also drives two single-cycle pulses that a setpoint scheduler uses. Each pulse is tied to a fixed time of day. A pulse is raised only in the clock cycle where a minute advance lands on its target time. Holding a matching time does not raise it again.

The cycles per minute and both target times are parameters, so a short configuration can be used for simulation. Reset is synchronous and active high.

Top module: `daytime_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the next state shows minute 0, hour 0, and both pulses low.
- R2: The minute advances exactly once every `TICKS_PER_MIN` clock cycles with reset low. The first advance comes `TICKS_PER_MIN` edges after reset is released.
- R3: The minute counts from 0 to 59 in plain binary. An advance from minute 59 gives minute 0 and increments the hour, so 00:59 becomes 01:00.
- R4: The hour counts from 0 to 23 in plain binary. An advance from 23:59 gives 00:00.
- R5: `sched_a` is high for exactly one cycle: the cycle in which the time first reads `A_HOUR`:`A_MIN` after an advance. It is low at all other times.
- R6: `sched_b` is high for exactly one cycle: the cycle in which the time first reads `B_HOUR`:`B_MIN` after an advance. It is low at all other times.
- R7: A reset in the middle of a minute also clears the cycle prescaler. After release, the next advance again takes a full `TICKS_PER_MIN` cycles.
- R8: Between advances, the minute and hour outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (slow tick source) |
| rst | input | 1 | Synchronous reset, active high |
| minute | output | 6 | Current minute, 0 to 59 |
| hour | output | 5 | Current hour, 0 to 23 |
| sched_a | output | 1 | One-cycle pulse on reaching the first schedule time |
| sched_b | output | 1 | One-cycle pulse on reaching the second schedule time |

## Verification
The bench builds the block with 18 cycles per minute and with schedule times of 02:00 and 03:00. With these values a whole simulated day, including the midnight wrap, fits in about 26,000 cycles. Both pulses fire early in that day, so their single-cycle width and their exact landing cycle are compared against a cycle-count model. The short minute also allows a mid-minute reset, followed by a check that the next advance needs a complete fresh minute.

// File: rtl/daytime_pkg.sv
package daytime_pkg;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int MIN_LAST  = 59;
  localparam int HOUR_LAST = 23;

  // Minute after an advance.
  function automatic logic [MIN_W-1:0] step_minute(input logic [MIN_W-1:0] m);
    return (m == MIN_W'(MIN_LAST)) ? '0 : m + 1'b1;
  endfunction

  // Hour after an advance; only moves when the minute wraps.
  function automatic logic [HOUR_W-1:0] step_hour(input logic [HOUR_W-1:0] h,
                                                  input logic [MIN_W-1:0]  m);
    if (m != MIN_W'(MIN_LAST)) return h;
    return (h == HOUR_W'(HOUR_LAST)) ? '0 : h + 1'b1;
  endfunction
endpackage

// File: rtl/daytime_prescaler.sv
module daytime_prescaler #(
  parameter int TICKS_PER_MIN = 7200
) (
  input  logic clk,
  input  logic rst,
  output logic adv
);
  localparam int CW = (TICKS_PER_MIN > 1) ? $clog2(TICKS_PER_MIN) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_MIN - 1);

  logic [CW-1:0] cnt;

  assign adv = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || adv) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/daytime_regs.sv
module daytime_regs
  import daytime_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [MIN_W-1:0]  minute,
  output logic [HOUR_W-1:0] hour,
  output logic [MIN_W-1:0]  minute_nx,
  output logic [HOUR_W-1:0] hour_nx
);
  assign minute_nx = step_minute(minute);
  assign hour_nx   = step_hour(hour, minute);

  always_ff @(posedge clk) begin
    if (rst) begin
      minute <= '0;
      hour   <= '0;
    end else if (adv) begin
      minute <= minute_nx;
      hour   <= hour_nx;
    end
  end
endmodule

// File: rtl/daytime_match.sv
module daytime_match
  import daytime_pkg::*;
#(
  parameter int HOUR_AT = 9,
  parameter int MIN_AT  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [MIN_W-1:0]  minute_nx,
  input  logic [HOUR_W-1:0] hour_nx,
  output logic              pulse
);
  logic hit;
  assign hit = adv && (minute_nx == MIN_W'(MIN_AT)) && (hour_nx == HOUR_W'(HOUR_AT));

  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= hit;
  end
endmodule

// File: rtl/daytime_counter.sv
module daytime_counter
  import daytime_pkg::*;
#(
  parameter int TICKS_PER_MIN = 7200,
  parameter int A_HOUR = 9,
  parameter int A_MIN  = 0,
  parameter int B_HOUR = 19,
  parameter int B_MIN  = 0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [MIN_W-1:0]  minute,
  output logic [HOUR_W-1:0] hour,
  output logic              sched_a,
  output logic              sched_b
);
  logic              minute_adv;
  logic [MIN_W-1:0]  minute_nx;
  logic [HOUR_W-1:0] hour_nx;

  daytime_prescaler #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_pre (
    .clk(clk), .rst(rst), .adv(minute_adv)
  );

  daytime_regs u_regs (
    .clk(clk), .rst(rst), .adv(minute_adv),
    .minute(minute), .hour(hour),
    .minute_nx(minute_nx), .hour_nx(hour_nx)
  );

  daytime_match #(.HOUR_AT(A_HOUR), .MIN_AT(A_MIN)) u_match_a (
    .clk(clk), .rst(rst), .adv(minute_adv),
    .minute_nx(minute_nx), .hour_nx(hour_nx), .pulse(sched_a)
  );

  daytime_match #(.HOUR_AT(B_HOUR), .MIN_AT(B_MIN)) u_match_b (
    .clk(clk), .rst(rst), .adv(minute_adv),
    .minute_nx(minute_nx), .hour_nx(hour_nx), .pulse(sched_b)
  );
endmodule

// File: rtl/daytime_counter_checker.sv
module daytime_counter_checker #(
  parameter int A_HOUR = 9,
  parameter int A_MIN  = 0,
  parameter int B_HOUR = 19,
  parameter int B_MIN  = 0
) (
  input logic       clk,
  input logic       rst,
  input logic       adv,
  input logic [5:0] minute,
  input logic [4:0] hour,
  input logic       sched_a,
  input logic       sched_b
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (minute == 6'd0 && hour == 5'd0 && !sched_a && !sched_b));

  a_r3_minute_range: assert property (@(posedge clk) disable iff (rst)
    minute < 6'd60);

  a_r3_minute_wrap: assert property (@(posedge clk) disable iff (rst)
    (adv && minute == 6'd59) |=> (minute == 6'd0));

  a_r4_hour_range: assert property (@(posedge clk) disable iff (rst)
    hour < 5'd24);

  a_r4_midnight: assert property (@(posedge clk) disable iff (rst)
    (adv && minute == 6'd59 && hour == 5'd23) |=> (minute == 6'd0 && hour == 5'd0));

  a_r5_single_cycle: assert property (@(posedge clk) disable iff (rst)
    sched_a |=> !sched_a);

  a_r5_at_target: assert property (@(posedge clk) disable iff (rst)
    sched_a |-> (minute == 6'(A_MIN) && hour == 5'(A_HOUR)));

  a_r6_single_cycle: assert property (@(posedge clk) disable iff (rst)
    sched_b |=> !sched_b);

  a_r6_at_target: assert property (@(posedge clk) disable iff (rst)
    sched_b |-> (minute == 6'(B_MIN) && hour == 5'(B_HOUR)));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(minute) && $stable(hour)));
endmodule

bind daytime_counter daytime_counter_checker #(
  .A_HOUR(A_HOUR), .A_MIN(A_MIN), .B_HOUR(B_HOUR), .B_MIN(B_MIN)
) u_chk (
  .clk(clk), .rst(rst), .adv(minute_adv),
  .minute(minute), .hour(hour),
  .sched_a(sched_a), .sched_b(sched_b)
);

// File: tb/daytime_counter_bench.sv
`timescale 1ns/1ps
module daytime_counter_bench;
  localparam int N  = 18;
  localparam int AH = 2, AM = 0, BH = 3, BM = 0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] minute;
  logic [4:0] hour;
  logic       sched_a, sched_b;

  int compared = 0;
  int mismatched = 0;
  int k = 0;          // rising edges seen with reset low since last release
  bit done = 1'b0;

  always #5 clk = ~clk;

  daytime_counter #(.TICKS_PER_MIN(N), .A_HOUR(AH), .A_MIN(AM),
                    .B_HOUR(BH), .B_MIN(BM)) u_daytime_counter (
    .clk(clk), .rst(rst), .minute(minute), .hour(hour),
    .sched_a(sched_a), .sched_b(sched_b)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s %s at k=%0d: got %0d expected %0d", req, what, k, got, exp);
    end
  endtask

  // Reference: whole minutes elapsed since release, as a cycle count.
  task automatic check_model(input string req);
    int total = k / N;
    int day   = total % 1440;
    bit on_adv = (k > 0) && (k % N == 0);
    check(req, "minute", int'(minute), day % 60);
    check(req, "hour", int'(hour), day / 60);
    check("R5", "sched_a", int'(sched_a), int'(on_adv && day == AH*60+AM));
    check("R6", "sched_b", int'(sched_b), int'(on_adv && day == BH*60+BM));
  endtask

  task automatic step();
    @(posedge clk);
    if (!rst) k++;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(); step();
    check("R1", "minute", int'(minute), 0);
    check("R1", "hour", int'(hour), 0);
    check("R1", "sched_a", int'(sched_a), 0);
    check("R1", "sched_b", int'(sched_b), 0);
    rst = 1'b0;
    k = 0;
  endtask

  // Run past midnight, comparing every cycle (R2, R3, R4, R8 plus pulses).
  task automatic t_full_day();
    bit saw_a = 0, saw_b = 0, saw_0100 = 0, saw_midnight = 0;
    for (int i = 0; i < 1441*N + 3; i++) begin
      step();
      check((k % N == 0) ? "R2" : "R8", "model", 0, 0);
      check_model((k / N) % 60 == 0 ? "R3" : "R2");
      if (sched_a) saw_a = 1;
      if (sched_b) saw_b = 1;
      if (k == 60*N) saw_0100 = (minute == 0 && hour == 1);
      if (k == 1440*N) saw_midnight = (minute == 0 && hour == 0);
    end
    check("R5", "sched_a seen", int'(saw_a), 1);
    check("R6", "sched_b seen", int'(saw_b), 1);
    check("R3", "00:59 to 01:00", int'(saw_0100), 1);
    check("R4", "23:59 to 00:00", int'(saw_midnight), 1);
  endtask

  // Reset part-way into a minute; the next advance needs a full minute again.
  task automatic t_midminute_reset();
    for (int i = 0; i < 3*N + 7; i++) step();
    rst = 1'b1;
    step();
    check("R7", "minute in reset", int'(minute), 0);
    rst = 1'b0;
    k = 0;
    for (int i = 0; i < N - 1; i++) begin
      step();
      check("R7", "minute before full minute", int'(minute), 0);
    end
    step();
    check("R7", "minute after full minute", int'(minute), 1);
    check("R7", "hour", int'(hour), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_full_day();
    t_midminute_reset();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule